// File: doc/BRIEF.md
# Patch Sum Threshold Trigger

This block turns a grid of digitized channel samples into a prompt local trigger. Each channel already carries the analog sum of a 2x2 group of detector towers. Channels are laid out as a grid of `ROWS` x `COLS`, which is 8 x 12 by default. In every clock cycle the block adds each 2x2 neighbourhood of channels. The result is one patch energy that covers 4x4 towers. Patches overlap and slide by one channel, so the default grid gives 77 patches.

All patch sums are formed in parallel. Each sum is compared against a threshold that belongs to that patch alone. The block reports two results: a hit vector with one bit per patch, and a single trigger that is the OR of all hit bits. A global enable can mask the trigger, while the hit vector stays visible for debug. Thresholds are written through a simple write port. The pipeline has a fixed depth of three register stages, so the result fits well inside the short budget of a prompt trigger at a 40 MHz sample rate.

Top module: `patch_trigger`

## Requirements
- R1: After synchronous reset, `hit_vec` and `trig` are zero and every threshold holds the all-ones value 16383. Even with all channels at full scale (4095) and valid, no patch hits.
- R2: A patch hits when its 14-bit sum is greater than or equal to its threshold. A sum exactly equal to the threshold hits, and one below it does not. Four full-scale channels sum to 16380 without wrapping.
- R3: A sample presented before rising edge t appears in `hit_vec` and `trig` just after edge t+2. Every sample gives exactly one cycle of result, so back-to-back samples give back-to-back results.
- R4: With the enable high, `trig` is high exactly when at least one bit of `hit_vec` for the same sample is high.
- R5: With `trig_en` low, `trig` stays low, while `hit_vec` still reports the patch hits.
- R6: A channel whose valid bit is low adds zero to every patch that contains it, whatever its data.
- R7: A sample in which no channel is valid produces no hits, even for a patch whose threshold is 0.
- R8: A threshold write with `thr_addr` at or above the patch count changes no threshold.
- R9: Each patch compares against its own threshold. A write at a falling edge with `thr_we` high sets that patch's threshold to `thr_data`, and this governs every compare that comes after the next rising edge.
- R10: Channel (row r, column c) has index r*COLS+c and is carried on `chan_data` bits [index*12 +: 12] with valid bit `chan_valid[index]`. Patch (r, c) for r < ROWS-1 and c < COLS-1 has index r*(COLS-1)+c and adds channels (r,c), (r,c+1), (r+1,c) and (r+1,c+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_data | input | 1152 | Flattened channel samples, 12 bits each |
| chan_valid | input | 96 | Per-channel valid strobe |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | 7 | Patch index of the threshold write |
| thr_data | input | 14 | Threshold value to write |
| trig_en | input | 1 | Global trigger enable |
| hit_vec | output | 77 | Per-patch hit flags |
| trig | output | 1 | OR of the hit flags, masked by the enable |

## Verification
Each sample driven at a falling edge is registered at the next rising edge. Its hit vector and trigger are therefore due three falling edges later, once the input, adder and compare registers have all clocked. The driver tags every expected item with that due cycle, and the monitor compares each item only at the falling edge whose cycle count matches. Threshold and enable changes are made only while idle samples fill the pipeline. This way every in-flight sample is judged against the configuration its compare stage actually uses.

// File: rtl/patch_pkg.sv
// Package: shared index helpers for the patch trigger.
// Assumes a row-major channel grid and 2x2 patches that slide by one channel.
package patch_pkg;

    // Number of overlapping 2x2 patches in a rows x cols grid.
    function automatic int patch_total(input int rows, input int cols);
        return (rows - 1) * (cols - 1);
    endfunction

    // Row-major flat index of a channel.
    function automatic int chan_index(input int row, input int col, input int cols);
        return row * cols + col;
    endfunction

endpackage

// File: rtl/patch_in_reg.sv
// Module: input stage. Registers channel samples, replacing invalid channels with zero.
// Also derives a per-sample valid that is high when any channel is valid.
// Assumes one sample per clock with no back-pressure.
module patch_in_reg #(
    parameter int NCH = 96,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] din,
    input  logic [NCH-1:0]    din_vld,
    output logic [NCH*DW-1:0] dq,
    output logic              sample_vld
);

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_ch
            // Latch one channel and force it to zero when its strobe is low.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dq[i*DW +: DW] <= '0;
                else
                    dq[i*DW +: DW] <= din_vld[i] ? din[i*DW +: DW] : '0;
            end
        end
    endgenerate

    // Carry the sample-level valid alongside the data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_vld <= 1'b0;
        else
            sample_vld <= |din_vld;
    end

endmodule

// File: rtl/patch_adder.sv
// Module: patch adder. Forms every 2x2 channel sum in parallel and registers it.
// Assumes SW is at least DW+2, so four full-scale samples never overflow.
module patch_adder
    import patch_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 12,
    parameter int DW   = 12,
    parameter int SW   = 14,
    localparam int NCH = ROWS * COLS,
    localparam int NP  = patch_total(ROWS, COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] dq,
    input  logic              vld_in,
    output logic [NP*SW-1:0]  sums,
    output logic              vld_out
);

    genvar r, c;
    generate
        for (r = 0; r < ROWS - 1; r++) begin : g_row
            for (c = 0; c < COLS - 1; c++) begin : g_col
                localparam int P  = r * (COLS - 1) + c;
                localparam int A0 = chan_index(r,     c,     COLS);
                localparam int A1 = chan_index(r,     c + 1, COLS);
                localparam int B0 = chan_index(r + 1, c,     COLS);
                localparam int B1 = chan_index(r + 1, c + 1, COLS);
                // Register the four-channel sum of one patch.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        sums[P*SW +: SW] <= '0;
                    else
                        sums[P*SW +: SW] <= SW'(dq[A0*DW +: DW]) + SW'(dq[A1*DW +: DW])
                                          + SW'(dq[B0*DW +: DW]) + SW'(dq[B1*DW +: DW]);
                end
            end
        end
    endgenerate

    // Pass the sample valid alongside the sums.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_out <= 1'b0;
        else
            vld_out <= vld_in;
    end

endmodule

// File: rtl/patch_thr_bank.sv
// Module: threshold bank. Holds one threshold per patch, reset to all ones.
// Assumes a single write port. Addresses with no patch behind them are dropped.
module patch_thr_bank #(
    parameter int NP = 77,
    parameter int SW = 14,
    parameter int AW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [SW-1:0]    wdata,
    output logic [NP*SW-1:0] thr
);

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_thr
            // Update one patch threshold on a write that matches its index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    thr[p*SW +: SW] <= '1;
                else if (we && addr == AW'(p))
                    thr[p*SW +: SW] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/patch_cmp.sv
// Module: compare stage. Flags each patch at or above its threshold and ORs the flags.
// Assumes the sums and thresholds are aligned to the same sample.
module patch_cmp #(
    parameter int NP = 77,
    parameter int SW = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP*SW-1:0] sums,
    input  logic [NP*SW-1:0] thr,
    input  logic             vld,
    input  logic             en,
    output logic [NP-1:0]    hits,
    output logic             trig
);

    logic [NP-1:0] ge;

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_ge
            assign ge[p] = sums[p*SW +: SW] >= thr[p*SW +: SW];
        end
    endgenerate

    // Register the hit flags and the masked OR trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hits <= '0;
            trig <= 1'b0;
        end else begin
            hits <= vld ? ge : '0;
            trig <= en & vld & (|ge);
        end
    end

endmodule

// File: rtl/patch_trigger.sv
// Module: top level of the patch threshold trigger.
// It takes a grid of 2x2 tower sums, builds overlapping 2x2 channel patches,
// compares each patch with its own threshold and raises an OR trigger.
// Assumes one sample per clock. Latency is three register stages.
module patch_trigger
    import patch_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 12,
    parameter int DW   = 12,
    localparam int NCH = ROWS * COLS,
    localparam int NP  = patch_total(ROWS, COLS),
    localparam int SW  = DW + 2,
    localparam int AW  = $clog2(NP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] chan_data,
    input  logic [NCH-1:0]    chan_valid,
    input  logic              thr_we,
    input  logic [AW-1:0]     thr_addr,
    input  logic [SW-1:0]     thr_data,
    input  logic              trig_en,
    output logic [NP-1:0]     hit_vec,
    output logic              trig
);

    logic [NCH*DW-1:0] dq;
    logic              vld_s1;
    logic [NP*SW-1:0]  sums;
    logic              vld_s2;
    logic [NP*SW-1:0]  thr;

    patch_in_reg #(.NCH(NCH), .DW(DW)) u_in (
        .clk(clk), .rst_n(rst_n), .din(chan_data), .din_vld(chan_valid),
        .dq(dq), .sample_vld(vld_s1)
    );

    patch_adder #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .SW(SW)) u_add (
        .clk(clk), .rst_n(rst_n), .dq(dq), .vld_in(vld_s1),
        .sums(sums), .vld_out(vld_s2)
    );

    patch_thr_bank #(.NP(NP), .SW(SW), .AW(AW)) u_thr (
        .clk(clk), .rst_n(rst_n), .we(thr_we), .addr(thr_addr),
        .wdata(thr_data), .thr(thr)
    );

    patch_cmp #(.NP(NP), .SW(SW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .sums(sums), .thr(thr), .vld(vld_s2),
        .en(trig_en), .hits(hit_vec), .trig(trig)
    );

endmodule

// File: rtl/patch_trigger_chk.sv
// Module: assertion checker for patch_trigger, attached with bind.
// Assumes the three-stage pipeline from sample input to outputs.
module patch_trigger_chk #(
    parameter int NCH = 96,
    parameter int NP  = 77
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] chan_valid,
    input logic           trig_en,
    input logic [NP-1:0]  hit_vec,
    input logic           trig
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (hit_vec == '0 && !trig));

    a_r4_trig_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (hit_vec != '0));

    a_r4_hit_raises_trig: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trig_en) && hit_vec != '0) |-> trig);

    a_r5_enable_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(trig_en) |-> !trig);

    a_r7_no_valid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chan_valid, 3) == '0) |-> (hit_vec == '0));

endmodule

bind patch_trigger patch_trigger_chk #(.NCH(NCH), .NP(NP)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_valid(chan_valid),
    .trig_en(trig_en), .hit_vec(hit_vec), .trig(trig)
);

// File: tb/sim_patch_trigger.sv
module sim_patch_trigger;
    localparam int PERIOD = 25;
    localparam int ROWS = 8;
    localparam int COLS = 12;
    localparam int DW   = 12;
    localparam int NCH  = ROWS * COLS;
    localparam int NP   = (ROWS - 1) * (COLS - 1);
    localparam int SW   = DW + 2;
    localparam int AW   = 7;

    typedef struct {
        int          due;
        logic [NP-1:0] hits;
        logic        trg;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*DW-1:0] chan_data = '0;
    logic [NCH-1:0]    chan_valid = '0;
    logic              thr_we = 1'b0;
    logic [AW-1:0]     thr_addr = '0;
    logic [SW-1:0]     thr_data = '0;
    logic              trig_en = 1'b0;
    logic [NP-1:0]     hit_vec;
    logic              trig;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    exp_t q[$];

    int mthr[NP];
    bit men = 0;
    int ch[NCH];
    bit vm[NCH];
    bit wr_pend = 0;
    int wr_a = 0;
    int wr_d = 0;
    int unsigned seed = 32'h1234_5678;

    patch_trigger u0 (
        .clk(clk), .rst_n(rst_n), .chan_data(chan_data), .chan_valid(chan_valid),
        .thr_we(thr_we), .thr_addr(thr_addr), .thr_data(thr_data),
        .trig_en(trig_en), .hit_vec(hit_vec), .trig(trig)
    );

    always #(PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(input int m);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % m);
    endfunction

    // Drive one sample (plus any pending threshold write) and queue its expected result.
    task automatic tick(input string tag);
        exp_t e;
        bit anyv;
        @(negedge clk);
        anyv = 0;
        for (int i = 0; i < NCH; i++) begin
            chan_data[i*DW +: DW] = DW'(ch[i]);
            chan_valid[i] = vm[i];
            anyv |= vm[i];
        end
        if (wr_pend) begin
            thr_we = 1'b1;
            thr_addr = AW'(wr_a);
            thr_data = SW'(wr_d);
            if (wr_a < NP) mthr[wr_a] = wr_d;
            wr_pend = 0;
        end else begin
            thr_we = 1'b0;
        end
        trig_en = men;
        e.hits = '0;
        for (int r = 0; r < ROWS - 1; r++) begin
            for (int c = 0; c < COLS - 1; c++) begin
                int s;
                int p;
                p = r * (COLS - 1) + c;
                s = 0;
                if (vm[r*COLS+c])       s += ch[r*COLS+c];
                if (vm[r*COLS+c+1])     s += ch[r*COLS+c+1];
                if (vm[(r+1)*COLS+c])   s += ch[(r+1)*COLS+c];
                if (vm[(r+1)*COLS+c+1]) s += ch[(r+1)*COLS+c+1];
                e.hits[p] = anyv && (s >= mthr[p]);
            end
        end
        e.trg = men && (e.hits != '0);
        e.due = cyc + 3;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic fill(input int v, input bit valid);
        for (int i = 0; i < NCH; i++) begin
            ch[i] = v;
            vm[i] = valid;
        end
    endtask

    task automatic idle(input int n);
        fill(0, 0);
        for (int k = 0; k < n; k++) tick("idle");
    endtask

    task automatic write_thr(input int a, input int d, input string tag);
        fill(0, 0);
        wr_pend = 1;
        wr_a = a;
        wr_d = d;
        tick(tag);
    endtask

    task automatic rand_sample(input int m, input bit rand_valid, input string tag);
        for (int i = 0; i < NCH; i++) begin
            ch[i] = rnd(m);
            vm[i] = rand_valid ? (rnd(4) != 0) : 1'b1;
        end
        tick(tag);
    endtask

    // Monitor: compare each expected item at its due falling edge.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            total += 2;
            if (hit_vec !== e.hits) begin
                bad++;
                $display("FAIL %s hit_vec got=%h exp=%h", e.tag, hit_vec, e.hits);
            end
            if (trig !== e.trg) begin
                bad++;
                $display("FAIL %s/R4 trig got=%0b exp=%0b", e.tag, trig, e.trg);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) mthr[p] = (1 << SW) - 1;
        fill(0, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (hit_vec !== '0 || trig !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset outputs got=%h/%0b exp=0/0", hit_vec, trig);
        end
        men = 1;
        idle(3);

        // R1: full scale with reset thresholds never fires
        fill(4095, 1); tick("R1");
        idle(3);

        // R2: thresholds at 16380, full scale reaches them without wrap
        for (int p = 0; p < NP; p++) write_thr(p, 16380, "R9");
        idle(3);
        fill(4095, 1); tick("R2");
        fill(4094, 1); tick("R2");
        idle(3);

        // R9: distinct per-patch thresholds
        for (int p = 0; p < NP; p++) write_thr(p, 1000 + p * 10, "R9");
        idle(3);

        // R10/R3: back-to-back random patterns
        for (int k = 0; k < 20; k++) rand_sample(512, 0, "R10");
        idle(3);

        // R2 boundary: one hot channel shared by four patches
        fill(0, 1); ch[3*COLS+7] = 1400; tick("R2");
        fill(0, 1); ch[3*COLS+7] = 1399; tick("R2");
        idle(3);

        // R6: invalid channels contribute nothing
        for (int k = 0; k < 10; k++) rand_sample(1024, 1, "R6");
        fill(4095, 0); vm[0] = 1; ch[0] = 0; tick("R6");
        idle(3);

        // R7: no valid channel, even with a zero threshold
        write_thr(5, 0, "R9");
        idle(3);
        fill(4095, 0); tick("R7");
        fill(0, 0); vm[50] = 1; tick("R7");
        idle(3);

        // R8: out-of-range writes change nothing
        write_thr(77, 0, "R8");
        write_thr(77 + 13 - 13 + 64 - 64, 0, "R8");
        write_thr(127, 0, "R8");
        write_thr(90, 0, "R8");
        idle(3);
        fill(1, 1); tick("R8");
        fill(300, 1); tick("R8");
        idle(3);

        // R5: enable low masks trig but not hit_vec
        men = 0;
        idle(3);
        for (int k = 0; k < 5; k++) rand_sample(512, 0, "R5");
        fill(4095, 1); tick("R5");
        idle(3);
        men = 1;
        idle(3);

        // R3: single pulse then quiet
        fill(4095, 1); tick("R3");
        idle(4);
        fill(2000, 1); tick("R3");
        fill(0, 1); tick("R3");
        fill(2000, 1); tick("R3");
        idle(5);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule